// File: doc/BRIEF.md
# Channel-Quality Constraint-Length Selector

This controller decides which constraint length a convolutional decoder runs with. A measured signal-to-noise figure arrives as an unsigned value in tenths of a dB. A strobe arrives once for each decoded symbol. Each time a fixed number of symbols has been counted, the controller picks a new constraint length. It takes the smallest one whose SNR requirement the current measurement meets. A short code length saves power on a clean channel, and a long one keeps the correcting strength on a noisy channel.

The chosen length is held until the next decision point. A one-cycle strobe tells the configuration logic that a change is due. The controller also gives the datapath sequencer the number of clock cycles each symbol takes at the current length. A restricted input narrows the choice to the odd lengths 3, 5 and 7, for systems that keep only those decoders resident.

There is no data stream through this block. Every pin is a plain level or strobe, so no valid/ready handshake and no back-pressure exist.

Top module: `kls_selector`

## Requirements
- R1: Reset, and any reset applied in the middle of an interval, sets the selected length to 7 and the cycles-per-symbol output to 7, clears the strobe, and restarts the symbol count from zero.
- R2: A decision is taken only on the clock edge that accepts the INTERVAL-th symbol strobe since the last decision or reset. Cycles without a strobe do not advance the count. The SNR and mode inputs have no effect at any other time.
- R3: In full mode the chosen length is the smallest of 3..7 whose threshold is at most the SNR value. The thresholds in tenths of a dB are 53 for K=3, 49 for K=4, 43 for K=5, 38 for K=6 and 32 for K=7. A value exactly at a threshold meets it.
- R4: When the SNR value is below every threshold that is allowed, length 7 is chosen.
- R5: While the restricted input is high at the decision edge, only 3, 5 and 7 can be chosen, and the smallest allowed length whose threshold is met wins.
- R6: The switch strobe is high for the single cycle after a decision edge, and only when the new length differs from the previous one.
- R7: The cycles-per-symbol output follows the selected length: 4 for K=3, 5 for K=4, 5 for K=5, 6 for K=6, 7 for K=7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_tick | input | 1 | One pulse per decoded symbol |
| snr_db10 | input | SNR_W | Measured SNR, unsigned, tenths of a dB |
| restrict_set | input | 1 | High limits the choice to K = 3, 5, 7 |
| k_sel | output | 3 | Selected constraint length (3..7) |
| k_switch | output | 1 | One-cycle pulse when the selected length changes |
| clk_per_sym | output | 3 | Datapath clocks per symbol for k_sel |

## Verification
The assertions check on every cycle that the symbol count stays inside the interval and that the length holds steady between decisions. They also check that the length always lies between 3 and 7, that a strobe always goes with a real change, that a low measurement leads to length 7, and that restricted decisions land on an odd length. Only the bench scenarios can show the threshold table itself: the exact boundary values, and the smallest-met rule in both modes. The same holds for the exact tick on which a decision falls, for a reset that restarts a partly counted interval, and for the cycles-per-symbol mapping.

// File: rtl/kls_pkg.sv
package kls_pkg;
  typedef logic [2:0] klen_t;

  localparam int unsigned K_LO    = 3;
  localparam int unsigned K_COUNT = 5;
  localparam klen_t       K_HI    = 3'd7;

  // Required SNR, tenths of a dB, indexed by K - K_LO
  function automatic logic [7:0] snr_floor(input int unsigned idx);
    case (idx)
      0:       snr_floor = 8'd53;
      1:       snr_floor = 8'd49;
      2:       snr_floor = 8'd43;
      3:       snr_floor = 8'd38;
      default: snr_floor = 8'd32;
    endcase
  endfunction

  // Only odd lengths survive the restricted mode
  function automatic logic k_permitted(input int unsigned idx, input logic restr);
    k_permitted = !restr || ((idx % 2) == 0);
  endfunction

  function automatic klen_t cycles_for(input klen_t k);
    case (k)
      3'd3:    cycles_for = 3'd4;
      3'd4:    cycles_for = 3'd5;
      3'd5:    cycles_for = 3'd5;
      3'd6:    cycles_for = 3'd6;
      default: cycles_for = 3'd7;
    endcase
  endfunction
endpackage

// File: rtl/kls_symcount.sv
module kls_symcount #(
  parameter int unsigned INTERVAL = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic decide
);
  localparam int unsigned CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt;

  assign decide = tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (decide) cnt <= '0;
    else if (tick)   cnt <= cnt + 1'b1;
  end

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/kls_pick.sv
module kls_pick #(
  parameter int unsigned SNR_W = 8
) (
  input  logic [SNR_W-1:0] snr,
  input  logic             restr,
  output kls_pkg::klen_t   pick
);
  import kls_pkg::*;

  logic [K_COUNT-1:0] met;

  for (genvar i = 0; i < K_COUNT; i++) begin : g_cand
    localparam logic [SNR_W-1:0] FLOOR = SNR_W'(snr_floor(i));
    assign met[i] = k_permitted(i, restr) && (snr >= FLOOR);
  end

  // Smallest qualifying length wins; nothing met falls back to the longest
  always_comb begin
    pick = K_HI;
    for (int i = K_COUNT - 1; i >= 0; i--) begin
      if (met[i]) pick = klen_t'(K_LO + i);
    end
  end
endmodule

// File: rtl/kls_khold.sv
module kls_khold (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           decide,
  input  kls_pkg::klen_t pick,
  output kls_pkg::klen_t k_cur,
  output logic           k_switch
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      k_cur    <= kls_pkg::K_HI;
      k_switch <= 1'b0;
    end else begin
      k_switch <= decide && (pick != k_cur);
      if (decide) k_cur <= pick;
    end
  end

  assert_hold_between_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !decide |=> $stable(k_cur));
  assert_switch_real_R6: assert property (@(posedge clk) disable iff (!rst_n)
    k_switch |-> (k_cur != $past(k_cur)));
  assert_len_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (k_cur >= 3'd3) && (k_cur <= 3'd7));
endmodule

// File: rtl/kls_selector.sv
module kls_selector #(
  parameter int unsigned SNR_W    = 8,
  parameter int unsigned INTERVAL = 250000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_tick,
  input  logic [SNR_W-1:0] snr_db10,
  input  logic             restrict_set,
  output logic [2:0]       k_sel,
  output logic             k_switch,
  output logic [2:0]       clk_per_sym
);
  logic           decide;
  kls_pkg::klen_t pick;
  kls_pkg::klen_t k_cur;

  kls_symcount #(.INTERVAL(INTERVAL)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(sym_tick), .decide(decide)
  );

  kls_pick #(.SNR_W(SNR_W)) u_pick (
    .snr(snr_db10), .restr(restrict_set), .pick(pick)
  );

  kls_khold u_hold (
    .clk(clk), .rst_n(rst_n), .decide(decide), .pick(pick),
    .k_cur(k_cur), .k_switch(k_switch)
  );

  assign k_sel       = k_cur;
  assign clk_per_sym = kls_pkg::cycles_for(k_cur);

  assert_low_snr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && (snr_db10 < SNR_W'(32))) |=> (k_sel == 3'd7));
  assert_restrict_odd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && restrict_set) |=> k_sel[0]);
endmodule

// File: tb/test_kls_selector.sv
module test_kls_selector;
  localparam int unsigned IV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sym_tick = 1'b0;
  logic [7:0] snr = 8'd0;
  logic       restr = 1'b0;
  logic [2:0] k_sel, cps;
  logic       k_switch;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  kls_selector #(.SNR_W(8), .INTERVAL(IV)) i_kls_selector (
    .clk(clk), .rst_n(rst_n), .sym_tick(sym_tick), .snr_db10(snr),
    .restrict_set(restr), .k_sel(k_sel), .k_switch(k_switch),
    .clk_per_sym(cps)
  );

  // {restricted, snr in tenths dB, expected K}
  localparam logic [15:0] VEC [0:21] = '{
    {4'd0, 8'd60, 4'd3}, {4'd0, 8'd53, 4'd3}, {4'd0, 8'd52, 4'd4},
    {4'd0, 8'd49, 4'd4}, {4'd0, 8'd48, 4'd5}, {4'd0, 8'd43, 4'd5},
    {4'd0, 8'd42, 4'd6}, {4'd0, 8'd38, 4'd6}, {4'd0, 8'd37, 4'd7},
    {4'd0, 8'd32, 4'd7}, {4'd0, 8'd31, 4'd7}, {4'd0, 8'd255, 4'd3},
    {4'd1, 8'd60, 4'd3}, {4'd1, 8'd52, 4'd5}, {4'd1, 8'd48, 4'd5},
    {4'd1, 8'd42, 4'd7}, {4'd1, 8'd37, 4'd7}, {4'd1, 8'd43, 4'd5},
    {4'd1, 8'd10, 4'd7}, {4'd1, 8'd55, 4'd3}, {4'd0, 8'd45, 4'd5},
    {4'd0, 8'd0,  4'd7}
  };

  function automatic int exp_cps(input int k);
    return (k == 3) ? 4 : (k == 4) ? 5 : k;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input logic [7:0] s, input logic r);
    sym_tick = 1'b1; snr = s; restr = r;
    @(posedge clk); #1;
    sym_tick = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk); #1;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int prev_k;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    check("R1 k_sel", k_sel, 7);
    check("R1 cps", cps, 7);
    check("R1 strobe", k_switch, 0);

    // R2: gaps between ticks do not count; no decision before tick IV
    for (int i = 0; i < IV - 1; i++) begin
      tick(8'd255, 1'b0);
      idle(); idle();
      check("R2 hold", k_sel, 7);
      check("R2 no strobe", k_switch, 0);
    end
    tick(8'd20, 1'b0);
    check("R4 below all", k_sel, 7);
    check("R6 no change", k_switch, 0);

    // R1: reset in mid-interval restarts the count
    tick(8'd255, 1'b0);
    tick(8'd255, 1'b0);
    rst_n = 1'b0;
    idle(); idle();
    rst_n = 1'b1;
    for (int i = 0; i < IV - 1; i++) tick(8'd255, 1'b0);
    check("R1 restart", k_sel, 7);
    tick(8'd255, 1'b0);
    check("R1 decide after full interval", k_sel, 3);
    check("R6 strobe", k_switch, 1);
    idle();
    check("R6 one cycle", k_switch, 0);

    prev_k = 3;
    for (int v = 0; v < 22; v++) begin
      logic       r;
      logic [7:0] s;
      int         ek;
      string      tag;
      r  = VEC[v][12];
      s  = VEC[v][11:4];
      ek = int'(VEC[v][3:0]);
      tag = r ? "R5" : (s < 8'd32 ? "R4" : "R3");
      // Intermediate ticks carry opposite inputs; they must not matter (R2)
      for (int i = 0; i < IV - 1; i++) tick(~s, ~r);
      check("R2 mid-interval", k_sel, prev_k);
      tick(s, r);
      check(tag, k_sel, ek);
      check("R6 strobe", k_switch, (ek != prev_k) ? 1 : 0);
      check("R7 cps", cps, exp_cps(ek));
      idle();
      check("R6 pulse end", k_switch, 0);
      prev_k = ek;
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule